// File: doc/BRIEF.md
# Dual-Team Two-Digit Scoreboard

This block keeps a separate score for each of two teams and shows each score as two decimal digits on seven-segment outputs. Four push buttons drive it. Each team has one button that raises its score and one that lowers it. Every button passes through a two-stage synchronizer and a settle-time filter. After the filter, an edge detector turns each physical press into a single one-cycle step, so contact bounce never adds extra counts.

Each score is held as a tens digit and a units digit in BCD. The score saturates at 99 and at 00 and does not wrap. The four digit outputs are decoded combinationally from the stored digits. The settle time is set by the width of the filter counter, so the block can be adapted to a faster clock. Display scanning and any game rules beyond the score are not part of this block.

Top module: `sb_scoreboard`

## Requirements
- R1: Four active-high seven-segment outputs show team 1 tens, team 1 units, team 2 tens and team 2 units. Bit 6 is segment a and bit 0 is segment g. The digits 0..9 encode as 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111, 1111011, and any other code shows 0.
- R2: A recognised press on btn_i[0] adds one to the team 1 score, and one on btn_i[1] subtracts one from it.
- R3: A recognised press on btn_i[2] adds one to the team 2 score, and one on btn_i[3] subtracts one from it.
- R4: Each score is always a valid two-digit BCD value in the range 00..99.
- R5: Each button is sampled through two flip-flops, and any difference between the two stages restarts a settle counter of width CNT_W. The filtered level takes the synchronised value only while the counter MSB is set. If a new level is first sampled at edge k and then held, the score changes at edge k+3+2^(CNT_W-1). A pulse that lasts only a few cycles changes nothing.
- R6: A press is recognised when the filtered level falls from 1 to 0, so the buttons idle high. The release does not count, and a bouncing press counts exactly once.
- R7: An increment at 99 leaves the score at 99.
- R8: A decrement at 00 leaves the score at 00.
- R9: If a team's increment and decrement presses are recognised in the same cycle, that team's score does not change.
- R10: A units carry (09 to 10) or borrow (10 to 09) updates the tens digit in the same clock edge.
- R11: The active-low asynchronous reset sets both scores to 00 and clears all synchroniser, filter and edge-detector state.
- R12: A press for one team never changes the other team's score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_i | input | 4 | Raw buttons: [0] team 1 up, [1] team 1 down, [2] team 2 up, [3] team 2 down; idle high |
| seg_t1_tens_o | output | 7 | Team 1 tens digit, a..g |
| seg_t1_ones_o | output | 7 | Team 1 units digit, a..g |
| seg_t2_tens_o | output | 7 | Team 2 tens digit, a..g |
| seg_t2_ones_o | output | 7 | Team 2 units digit, a..g |

## Verification
A level that is first sampled at edge k and then held moves the score at edge k+3+2^(CNT_W-1). The segment outputs follow the score registers with no further register, so a new value shows on the same edge. The bench's reference model keeps a per-button run length of identical samples and a one-deep delayed copy of its filtered level. It steps all of its state at every rising edge and compares all four digits at the following falling edge. One directed check samples one edge before and one edge after the expected edge, to confirm the latency exactly. The other directed checks are taken only after a full release time, once every pending step is due.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int DIGIT_W = 4;
    localparam int SEG_W   = 7;

    typedef struct packed {
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] ones;
    } bcd_score_t;

    localparam bcd_score_t SCORE_ZERO = '{tens: 4'd0, ones: 4'd0};

endpackage

// File: rtl/sb_debounce.sv
module sb_debounce #(
    parameter int CNT_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic press_o
);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [CNT_W-1:0] cnt;
        logic             lvl;
        logic             dly;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw_i;
        st_d.s2 = st_q.s1;
        if (st_q.s1 ^ st_q.s2) begin
            st_d.cnt = '0;
        end else if (!st_q.cnt[CNT_W-1]) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (st_q.cnt[CNT_W-1]) begin
            st_d.lvl = st_q.s2;
        end
        st_d.dly = st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign press_o = st_q.dly & ~st_q.lvl;

endmodule

// File: rtl/sb_score.sv
module sb_score
    import sb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc_i,
    input  logic       dec_i,
    output bcd_score_t score_o
);

    bcd_score_t score_d, score_q;
    logic       at_top, at_bot;

    assign at_top = (score_q.tens == 4'd9) && (score_q.ones == 4'd9);
    assign at_bot = (score_q.tens == 4'd0) && (score_q.ones == 4'd0);

    always_comb begin
        score_d = score_q;
        if (inc_i && !dec_i && !at_top) begin
            if (score_q.ones == 4'd9) begin
                score_d.ones = 4'd0;
                score_d.tens = score_q.tens + 4'd1;
            end else begin
                score_d.ones = score_q.ones + 4'd1;
            end
        end else if (dec_i && !inc_i && !at_bot) begin
            if (score_q.ones == 4'd0) begin
                score_d.ones = 4'd9;
                score_d.tens = score_q.tens - 4'd1;
            end else begin
                score_d.ones = score_q.ones - 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score_q <= SCORE_ZERO;
        end else begin
            score_q <= score_d;
        end
    end

    assign score_o = score_q;

endmodule

// File: rtl/sb_seg7.sv
module sb_seg7
    import sb_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [SEG_W-1:0]   seg_o
);

    always_comb begin
        unique case (digit_i)
            4'd1:    seg_o = 7'b0110000;
            4'd2:    seg_o = 7'b1101101;
            4'd3:    seg_o = 7'b1111001;
            4'd4:    seg_o = 7'b0110011;
            4'd5:    seg_o = 7'b1011011;
            4'd6:    seg_o = 7'b1011111;
            4'd7:    seg_o = 7'b1110000;
            4'd8:    seg_o = 7'b1111111;
            4'd9:    seg_o = 7'b1111011;
            default: seg_o = 7'b1111110;
        endcase
    end

endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] btn_i,
    output logic [6:0] seg_t1_tens_o,
    output logic [6:0] seg_t1_ones_o,
    output logic [6:0] seg_t2_tens_o,
    output logic [6:0] seg_t2_ones_o
);

    localparam int NUM_TEAMS  = 2;
    localparam int NUM_BTN    = 2 * NUM_TEAMS;
    localparam int NUM_DIGITS = 2 * NUM_TEAMS;

    logic [NUM_BTN-1:0]          press;
    bcd_score_t                  score_t1, score_t2;
    bcd_score_t                  scores   [NUM_TEAMS];
    logic [DIGIT_W-1:0]          digits   [NUM_DIGITS];
    logic [SEG_W-1:0]            segs     [NUM_DIGITS];

    for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
        sb_debounce #(.CNT_W(CNT_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (btn_i[b]),
            .press_o(press[b])
        );
    end

    for (genvar t = 0; t < NUM_TEAMS; t++) begin : g_team
        sb_score u_score (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc_i  (press[2*t]),
            .dec_i  (press[2*t+1]),
            .score_o(scores[t])
        );
        assign digits[2*t]   = scores[t].tens;
        assign digits[2*t+1] = scores[t].ones;
    end

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
        sb_seg7 u_seg (
            .digit_i(digits[g]),
            .seg_o  (segs[g])
        );
    end

    assign score_t1      = scores[0];
    assign score_t2      = scores[1];
    assign seg_t1_tens_o = segs[0];
    assign seg_t1_ones_o = segs[1];
    assign seg_t2_tens_o = segs[2];
    assign seg_t2_ones_o = segs[3];

endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk
    import sb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] press,
    input bcd_score_t score_t1,
    input bcd_score_t score_t2
);

    function automatic int val(bcd_score_t s);
        return int'(s.tens) * 10 + int'(s.ones);
    endfunction

    p_bcd_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        score_t1.tens <= 4'd9 && score_t1.ones <= 4'd9 &&
        score_t2.tens <= 4'd9 && score_t2.ones <= 4'd9);

    p_t1_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (press[0] && !press[1] && val(score_t1) < 99)
        |=> val(score_t1) == val($past(score_t1)) + 1);

    p_t1_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (press[1] && !press[0] && val(score_t1) > 0)
        |=> val(score_t1) == val($past(score_t1)) - 1);

    p_t2_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (press[2] && !press[3] && val(score_t2) < 99)
        |=> val(score_t2) == val($past(score_t2)) + 1);

    p_t2_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (press[3] && !press[2] && val(score_t2) > 0)
        |=> val(score_t2) == val($past(score_t2)) - 1);

    p_sat_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (press[0] && val(score_t1) == 99) |=> val(score_t1) == 99);

    p_sat_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (press[3] && val(score_t2) == 0) |=> val(score_t2) == 0);

    p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (press[0] && press[1]) |=> $stable(score_t1));

    p_one_cycle_press_r6: assert property (@(posedge clk) disable iff (!rst_n)
        press[0] |=> !press[0]);

    p_idle_other_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (press[1:0] == 2'b00) |=> $stable(score_t1));

endmodule

bind sb_scoreboard sb_scoreboard_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .press   (press),
    .score_t1(score_t1),
    .score_t2(score_t2)
);

// File: tb/test_sb_scoreboard.sv
`timescale 1ns/1ps
module test_sb_scoreboard;

    localparam int CNT_W = 4;
    localparam int M     = 1 << (CNT_W - 1);
    localparam int HOLD  = M + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = 4'hF;
    logic [6:0] s1t, s1o, s2t, s2o;
    int total = 0;
    int bad = 0;

    sb_scoreboard #(.CNT_W(CNT_W)) i_sb_scoreboard (
        .clk(clk), .rst_n(rst_n), .btn_i(btn),
        .seg_t1_tens_o(s1t), .seg_t1_ones_o(s1o),
        .seg_t2_tens_o(s2t), .seg_t2_ones_o(s2o)
    );

    always #2.5 clk = ~clk;

    function automatic logic [6:0] seg_of(int d);
        case (d)
            0: return 7'b1111110; 1: return 7'b0110000; 2: return 7'b1101101;
            3: return 7'b1111001; 4: return 7'b0110011; 5: return 7'b1011011;
            6: return 7'b1011111; 7: return 7'b1110000; 8: return 7'b1111111;
            9: return 7'b1111011; default: return 7'b1111110;
        endcase
    endfunction

    function automatic logic [27:0] disp_of(int a, int b);
        return {seg_of(a / 10), seg_of(a % 10), seg_of(b / 10), seg_of(b % 10)};
    endfunction

    // Reference model: run length of equal samples, filtered level, delayed level
    int prev [4];
    int run  [4];
    bit lvl  [4];
    bit dly  [4];
    int sc   [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                prev[i] = 0; run[i] = 2; lvl[i] = 0; dly[i] = 0;
            end
            sc[0] = 0; sc[1] = 0;
        end else begin
            bit pr [4];
            for (int i = 0; i < 4; i++) pr[i] = dly[i] && !lvl[i];
            for (int t = 0; t < 2; t++) begin
                if (pr[2*t] && !pr[2*t+1] && sc[t] < 99) sc[t]++;
                else if (pr[2*t+1] && !pr[2*t] && sc[t] > 0) sc[t]--;
            end
            for (int i = 0; i < 4; i++) begin
                dly[i] = lvl[i];
                if (int'(btn[i]) == prev[i]) run[i]++;
                else begin prev[i] = int'(btn[i]); run[i] = 1; end
                if (run[i] >= M + 3) lvl[i] = (prev[i] != 0);
            end
        end
    end

    task automatic check(string req, logic [27:0] got, logic [27:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
        end
    endtask

    // R1: every cycle the digits match the model scores
    always @(negedge clk) begin
        check("R1 per-cycle", {s1t, s1o, s2t, s2o}, disp_of(sc[0], sc[1]));
    end

    task automatic expect_scores(string req, int a, int b);
        @(negedge clk);
        check(req, {s1t, s1o, s2t, s2o}, disp_of(a, b));
    endtask

    task automatic press(logic [3:0] mask);
        @(negedge clk); btn = btn & ~mask;
        repeat (HOLD) @(negedge clk);
        btn = btn | mask;
        repeat (HOLD) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R11 reset shows 00", {s1t, s1o, s2t, s2o}, disp_of(0, 0));
        rst_n = 1'b1;
        repeat (3 * M) @(negedge clk);
        expect_scores("R6 release after reset not counted", 0, 0);

        // R5 exact latency: low first sampled at edge k, step at k+3+M
        btn[0] = 1'b0;
        repeat (M + 3) @(posedge clk);
        @(negedge clk);
        check("R5 before due edge", {s1t, s1o, s2t, s2o}, disp_of(0, 0));
        @(posedge clk);
        @(negedge clk);
        check("R5 R2 at due edge", {s1t, s1o, s2t, s2o}, disp_of(1, 0));
        repeat (HOLD) @(negedge clk);
        btn[0] = 1'b1;
        repeat (HOLD) @(negedge clk);
        expect_scores("R6 release no count", 1, 0);

        for (int n = 2; n <= 12; n++) begin
            press(4'b0001);
            if (n == 9)  expect_scores("R2 team1 nine", 9, 0);
            if (n == 10) expect_scores("R10 carry 09 to 10", 10, 0);
        end
        expect_scores("R2 team1 twelve", 12, 0);
        press(4'b0010); press(4'b0010);
        expect_scores("R2 team1 down", 10, 0);
        press(4'b0010);
        expect_scores("R10 borrow 10 to 09", 9, 0);

        for (int n = 0; n < 5; n++) press(4'b0100);
        expect_scores("R3 R12 team2 up, team1 kept", 9, 5);
        press(4'b1000);
        expect_scores("R3 team2 down", 9, 4);

        // short glitch on team2 up
        @(negedge clk); btn[2] = 1'b0;
        repeat (3) @(negedge clk); btn[2] = 1'b1;
        repeat (2 * HOLD) @(negedge clk);
        expect_scores("R5 glitch ignored", 9, 4);

        // bouncing press on team1 up
        @(negedge clk); btn[0] = 1'b0;
        repeat (2) @(negedge clk); btn[0] = 1'b1;
        repeat (2) @(negedge clk); btn[0] = 1'b0;
        @(negedge clk); btn[0] = 1'b1;
        @(negedge clk); btn[0] = 1'b0;
        repeat (HOLD) @(negedge clk); btn[0] = 1'b1;
        @(negedge clk); btn[0] = 1'b0;
        @(negedge clk); btn[0] = 1'b1;
        repeat (HOLD) @(negedge clk);
        expect_scores("R6 bounce counts once", 10, 4);

        press(4'b0011);
        expect_scores("R9 up and down together", 10, 4);

        for (int n = 0; n < 6; n++) press(4'b1000);
        expect_scores("R8 team2 floor at 00", 10, 0);

        for (int n = 0; n < 91; n++) press(4'b0001);
        expect_scores("R7 R4 team1 ceiling at 99", 99, 0);
        press(4'b0100);
        expect_scores("R12 team2 alone", 99, 1);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid-run reset", {s1t, s1o, s2t, s2o}, disp_of(0, 0));
        rst_n = 1'b1;
        repeat (3 * M) @(negedge clk);
        press(4'b0100);
        expect_scores("R11 R3 clean restart", 0, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule